// File: doc/BRIEF.md
# Chained SPI Encoder Report Node

This block is one link in a string of SPI slaves that all hang off a single active-low select line. Each link holds a 24-bit report built from two parallel inputs: a 16-bit unsigned position from a quadrature counter and a 6-bit button hold time, counted in tenths of a second. When select returns high, the link takes a fresh snapshot of both inputs. While select is low, it shifts that snapshot out MSB first.

Each link shifts in its serial input at the same time as it shifts out. Once its own 24 bits have left, the bits that arrived from the next link upstream follow on the output in the same order. This lets a master read any number of links with one select line. The header of each record always starts with binary 10, so the master can count the links at run time.

SCK, select and the serial input are brought into the system clock domain through two-flop synchronizers. A one-cycle strobe tells the button timer that this link's record has been delivered.

Top module: `enc_chain_node`

## Requirements
- R1: The record, sent MSB first, is bit 23 = 1, bit 22 = 0, bits 21..16 = hold time and bits 15..0 = position.
- R2: The snapshot is taken when the synchronized select goes from low to high. Changes to the parallel inputs after that point do not alter the record shifted out.
- R3: Several select pulses with no read between them are harmless. A later read returns the values captured at the last rising edge of select.
- R4: While select is high, the serial output shows the record MSB (1) and the bit position goes back to the first bit. After a partial read and a new select pulse, the next read starts again with a complete record.
- R5: The serial input is sampled on the SCK rising edge and the serial output changes on the falling edge (mode 0). Bits entering the serial input appear on the output, in order, after this link's 24 bits.
- R6: `report_sent` is a single-cycle pulse raised once per select-low period, on the 24th SCK rising edge. A read of fewer than 24 bits raises no pulse.
- R7: SCK edges while select is high have no effect on the record or on `report_sent`.
- R8: If a select rising edge and an SCK rising edge reach the synchronized domain in the same cycle, select takes priority. The snapshot is reloaded, no shift happens and no pulse is raised.
- R9: After reset, the serial output is 1, `report_sent` is 0 and the stored record has zero hold time and zero position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the master (asynchronous) |
| ss_n | input | 1 | Shared active-low select; its rising edge latches the snapshot |
| sdi | input | 1 | Serial data from the upstream link |
| sdo | output | 1 | Serial data toward the master or the downstream link |
| pos_in | input | 16 | Parallel position value from the quadrature counter |
| hold_in | input | 6 | Parallel button hold time, in tenths of a second |
| report_sent | output | 1 | One-cycle strobe when the 24th record bit has been clocked out |

## Verification
The snapshot reload on a rising select and the shift triggered by an SCK rising edge can fall in the same synchronized cycle. The bench provokes this by clocking 23 bits, then raising select and SCK in the same instant. It judges the result in three ways:
- it expects no `report_sent` pulse;
- it expects the output to go back to 1;
- it expects the next full read to return the freshly latched record followed by the upstream bits.

A sweep over every hold value, with a varied position, checks the record layout and the upstream pass-through on each read.

// File: rtl/enc_chain_node.sv
module enc_chain_node #(
  parameter int POS_W       = 16,
  parameter int HOLD_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo,
  input  logic [POS_W-1:0]  pos_in,
  input  logic [HOLD_W-1:0] hold_in,
  output logic              report_sent
);
  localparam int REC_W = 2 + HOLD_W + POS_W;
  localparam int CNT_W = $clog2(REC_W + 1);

  logic [SYNC_STAGES-1:0] sck_sy, ss_sy, sdi_sy;
  logic sck_d, ss_d, in_bit;
  logic [REC_W-1:0] sr;
  logic [CNT_W-1:0] cnt;

  wire sck_s    = sck_sy[SYNC_STAGES-1];
  wire ss_s     = ss_sy[SYNC_STAGES-1];
  wire sdi_s    = sdi_sy[SYNC_STAGES-1];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire ss_rise  = ss_s & ~ss_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0;
      ss_sy  <= '1;
      sdi_sy <= '0;
      sck_d  <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      ss_sy  <= {ss_sy[SYNC_STAGES-2:0], ss_n};
      sdi_sy <= {sdi_sy[SYNC_STAGES-2:0], sdi};
      sck_d  <= sck_s;
      ss_d   <= ss_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr          <= {2'b10, {(REC_W-2){1'b0}}};
      cnt         <= '0;
      in_bit      <= 1'b0;
      report_sent <= 1'b0;
    end else begin
      report_sent <= 1'b0;
      if (ss_rise) begin
        sr  <= {2'b10, hold_in, pos_in};
        cnt <= '0;
      end else if (ss_s) begin
        cnt <= '0;
      end else begin
        if (sck_rise) begin
          in_bit <= sdi_s;
          if (cnt < CNT_W'(REC_W)) cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(REC_W - 1)) report_sent <= 1'b1;
        end
        if (sck_fall) sr <= {sr[REC_W-2:0], in_bit};
      end
    end

  assign sdo = sr[REC_W-1];
endmodule

module enc_chain_node_chk #(
  parameter int REC_W = 24,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ss_n,
  input logic             sdo,
  input logic             report_sent,
  input logic [CNT_W-1:0] bit_cnt
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    report_sent |=> !report_sent);
  a_r6_pulse_at_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    report_sent |-> bit_cnt == CNT_W'(REC_W));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(REC_W));
  a_r4_idle_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n, 1) && $past(ss_n, 2) && $past(ss_n, 3) && $past(ss_n, 4) && $past(ss_n, 5))
      |-> sdo);
  a_r7_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n, 1) && $past(ss_n, 2) && $past(ss_n, 3)) |-> !report_sent);
endmodule

bind enc_chain_node enc_chain_node_chk #(.REC_W(REC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sdo(sdo),
  .report_sent(report_sent), .bit_cnt(cnt)
);

// File: tb/tb_enc_chain_node.sv
`timescale 1ns/1ps
module tb_enc_chain_node;
  logic clk = 0, rst_n = 0, sck = 0, ss_n = 1, sdi = 0;
  logic [15:0] pos_in = 0;
  logic [5:0]  hold_in = 0;
  logic sdo, report_sent;
  int checks = 0, errors = 0, pulses = 0;

  enc_chain_node dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) if (report_sent) pulses++;

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch();
    ss_n = 0; w(4); ss_n = 1; w(8);
  endtask

  task automatic xfer(input logic [23:0] up, input int nbits, output logic [47:0] got);
    got = '0;
    ss_n = 0; w(6);
    for (int i = 0; i < nbits; i++) begin
      got[47-i] = sdo;
      sdi = (i < 24) ? up[23-i] : 1'b0;
      if (i == 5) begin pos_in = ~pos_in; hold_in = ~hold_in; end
      sck = 1; w(6);
      sck = 0; w(6);
    end
    ss_n = 1; w(8);
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] got;
    logic [23:0] rec, up;
    int p0;
    w(5); rst_n = 1; w(4);
    // R9 reset state
    chk(sdo === 1'b1, "R9 sdo", {47'd0, sdo}, 48'd1);
    chk(report_sent === 1'b0, "R9 report_sent", {47'd0, report_sent}, 48'd0);
    xfer(24'h0, 24, got);
    chk(got[47:24] === 24'h800000, "R9 reset record", {24'd0, got[47:24]}, 48'h800000);

    // R1 R2 R5 R6 sweep over every hold value
    for (int h = 0; h < 64; h++) begin
      hold_in = 6'(h);
      pos_in  = 16'(h * 1031) ^ 16'hA5C3;
      rec = {2'b10, hold_in, pos_in};
      up  = 24'(h * 40503) ^ 24'h5A96E1;
      latch();
      p0 = pulses;
      xfer(up, 48, got);
      chk(got[47:24] === rec, "R1 R2 record", {24'd0, got[47:24]}, {24'd0, rec});
      chk(got[23:0] === up, "R5 passthrough", {24'd0, got[23:0]}, {24'd0, up});
      chk(pulses - p0 == 1, "R6 one pulse", 48'(pulses - p0), 48'd1);
    end

    // R3 repeated latches, last one wins
    hold_in = 6'd7;  pos_in = 16'h1111; latch();
    hold_in = 6'd63; pos_in = 16'hFFFF; latch();
    hold_in = 6'd21; pos_in = 16'hBEEF; latch();
    rec = {2'b10, 6'd21, 16'hBEEF};
    xfer(24'h0, 24, got);
    chk(got[47:24] === rec, "R3 last latch", {24'd0, got[47:24]}, {24'd0, rec});

    // R4 R6 partial read then full record again
    hold_in = 6'd9; pos_in = 16'h0F0F; latch();
    p0 = pulses;
    xfer(24'h0, 10, got);
    chk(pulses == p0, "R6 no pulse short read", 48'(pulses - p0), 48'd0);
    chk(sdo === 1'b1, "R4 idle msb", {47'd0, sdo}, 48'd1);
    hold_in = 6'd33; pos_in = 16'h1234; latch();
    rec = {2'b10, 6'd33, 16'h1234};
    xfer(24'hC3C3C3, 48, got);
    chk(got[47:24] === rec, "R4 restart record", {24'd0, got[47:24]}, {24'd0, rec});
    chk(got[23:0] === 24'hC3C3C3, "R4 restart passthrough", {24'd0, got[23:0]}, 48'hC3C3C3);

    // R7 clock activity with select high
    hold_in = 6'd4; pos_in = 16'h8001; latch();
    p0 = pulses;
    for (int i = 0; i < 30; i++) begin
      sdi = i[0]; sck = 1; w(6); sck = 0; w(6);
    end
    chk(pulses == p0, "R7 no pulse", 48'(pulses - p0), 48'd0);
    chk(sdo === 1'b1, "R7 sdo", {47'd0, sdo}, 48'd1);
    rec = {2'b10, 6'd4, 16'h8001};
    xfer(24'h0, 24, got);
    chk(got[47:24] === rec, "R7 record intact", {24'd0, got[47:24]}, {24'd0, rec});

    // R8 select rise together with the 24th clock rise
    hold_in = 6'd50; pos_in = 16'h7E57; latch();
    p0 = pulses;
    ss_n = 0; w(6);
    for (int i = 0; i < 23; i++) begin
      sck = 1; w(6); sck = 0; w(6);
    end
    hold_in = 6'd18; pos_in = 16'h2468;
    sck = 1; ss_n = 1; w(8); sck = 0; w(8);
    chk(pulses == p0, "R8 no pulse on collision", 48'(pulses - p0), 48'd0);
    chk(sdo === 1'b1, "R8 sdo msb", {47'd0, sdo}, 48'd1);
    rec = {2'b10, 6'd18, 16'h2468};
    p0 = pulses;
    xfer(24'h00FF00, 48, got);
    chk(got[47:24] === rec, "R8 fresh record", {24'd0, got[47:24]}, {24'd0, rec});
    chk(got[23:0] === 24'h00FF00, "R8 passthrough", {24'd0, got[23:0]}, 48'h00FF00);
    chk(pulses - p0 == 1, "R8 R6 pulse after", 48'(pulses - p0), 48'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule